// File: doc/BRIEF.md
# Sample Level Threshold Detector with Dwell Qualification

This block watches a stream of two's complement converter samples, one per clock, and produces three fast flags for an external gain controller. It takes the magnitude of each sample and compares it with two programmable levels. The high flag follows single samples above the upper level, so the gain can be cut on the first large sample. The low flag reports a signal that has stayed quiet: it rises only after a programmed number of consecutive samples have all been below the lower level, and it drops on the first sample that is not.

A third flag carries the converter's own overrange indication through a fixed-latency shift pipeline, so that it lines up with the data path that follows. A single enable gates all three flags. The registers that hold the levels and the dwell count are outside this block and arrive as plain inputs.

Top module: `level_flag_det`

## Requirements
- R1: The magnitude of a sample is its absolute value read as a DATA_W-bit two's complement number, except that the most negative code (only the sign bit set) gives the largest positive magnitude, 2^(DATA_W-1)-1.
- R2: `hi_flag` is high in the cycle after a sample whose magnitude is strictly greater than `upper_lvl`, and low in the cycle after a sample whose magnitude is equal to or below it.
- R3: `lo_flag` goes high in the cycle after the N-th consecutive sample whose magnitude is strictly below `lower_lvl`, where N is `dwell_len`, and stays high while such samples continue.
- R4: A sample whose magnitude is equal to or above `lower_lvl` clears `lo_flag` in the next cycle and restarts the consecutive-sample count from zero.
- R5: A `dwell_len` of 0 behaves as 1.
- R6: The largest `dwell_len`, 65535 for the default 16-bit width, is honoured: the flag stays low after 65534 qualifying samples, rises after the 65535th, and stays high as further qualifying samples arrive.
- R7: `ovr_flag` shows the value of `smp_ovr` presented 12 clock cycles earlier (12 register stages).
- R8: A sample cycle with `det_en` low makes all three flags low in the next cycle, clears the consecutive-sample count and empties the overrange pipeline, so that no overrange seen before or during the disabled time reaches `ovr_flag`.
- R9: While `rst_n` is low at a clock edge, all flags, the count and the pipeline are cleared regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| det_en | input | 1 | Detector enable; low forces flags low and clears state |
| smp | input | DATA_W (14) | Converter sample, two's complement |
| smp_ovr | input | 1 | Overrange indication for the current sample |
| upper_lvl | input | DATA_W-1 (13) | Upper magnitude level |
| lower_lvl | input | DATA_W-1 (13) | Lower magnitude level |
| dwell_len | input | DWELL_W (16) | Consecutive below-level samples needed for the low flag |
| hi_flag | output | 1 | Previous sample above the upper level |
| lo_flag | output | 1 | Dwell time spent below the lower level |
| ovr_flag | output | 1 | Overrange indication delayed by 12 cycles |

## Verification
Directed runs place samples exactly on, one above and one below each level, and use the most negative code to tell a saturated magnitude from a wrapped one; a run of 65535 quiet samples separates a correct full-width dwell from an off-by-one or a wrapping counter. A single overrange pulse followed by zeros pins the latency to the exact cycle, and disabled cycles carrying overrange and loud samples show whether the enable really flushes the pipeline and restarts the dwell. Random blocks then mix quiet, loud, near-level and extreme samples with changing levels, dwell lengths, overrange pulses and brief enable drops, comparing every flag in every cycle with a bench model.

// File: rtl/level_flag_pkg.sv
// Shared defaults for the level threshold detector.
// Assumes: consumers override these through module parameters when needed.
package level_flag_pkg;
    localparam int unsigned DEF_DATA_W  = 14;
    localparam int unsigned DEF_DWELL_W = 16;
    localparam int unsigned DEF_OVR_LAT = 12;
endpackage

// File: rtl/level_flag_upper.sv
// Upper level compare: one registered flag per sample.
// Assumes: mag is the already saturated magnitude of the current sample.
module level_flag_upper #(
    parameter int unsigned MAG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [MAG_W-1:0] mag,
    input  logic [MAG_W-1:0] upper_lvl,
    output logic             flag
);
    // Register whether the present sample lies strictly above the level.
    always_ff @(posedge clk) begin
        if (!rst_n)  flag <= 1'b0;
        else if (!en) flag <= 1'b0;
        else         flag <= (mag > upper_lvl);
    end

    assert_hi_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mag > upper_lvl) |=> flag);
    assert_hi_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mag <= upper_lvl) |=> !flag);
endmodule

// File: rtl/level_flag_dwell.sv
// Lower level compare qualified by a saturating run-length counter.
// Assumes: dwell_len of zero is treated as one; counter saturates at all ones.
module level_flag_dwell #(
    parameter int unsigned MAG_W   = 13,
    parameter int unsigned DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [MAG_W-1:0]   mag,
    input  logic [MAG_W-1:0]   lower_lvl,
    input  logic [DWELL_W-1:0] dwell_len,
    output logic               flag
);
    localparam logic [DWELL_W-1:0] ONE = {{(DWELL_W-1){1'b0}}, 1'b1};

    logic [DWELL_W-1:0] run_cnt;
    logic [DWELL_W-1:0] run_nxt;
    logic [DWELL_W-1:0] need;
    logic               quiet;

    // Next run length and the effective dwell requirement.
    always_comb begin
        quiet   = (mag < lower_lvl);
        run_nxt = (run_cnt == '1) ? run_cnt : run_cnt + ONE;
        need    = (dwell_len == '0) ? ONE : dwell_len;
    end

    // Count consecutive quiet samples and raise the flag once enough are seen.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !quiet) begin
            run_cnt <= '0;
            flag    <= 1'b0;
        end else begin
            run_cnt <= run_nxt;
            flag    <= (run_nxt >= need);
        end
    end

    assert_lo_break_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mag >= lower_lvl) |=> (!flag && run_cnt == '0));
    assert_lo_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!flag && run_cnt == '0));
    assert_lo_counted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> (run_cnt != '0));
endmodule

// File: rtl/level_flag_ovr_pipe.sv
// Fixed-latency delay line for the converter overrange indication.
// Assumes: LAT >= 1; the whole line is flushed while disabled.
module level_flag_ovr_pipe #(
    parameter int unsigned LAT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ovr_in,
    output logic flag
);
    logic [LAT-1:0] stage;

    for (genvar gi = 0; gi < LAT; gi++) begin : g_stage
        if (gi == 0) begin : g_head
            // First stage captures the live indication.
            always_ff @(posedge clk) begin
                if (!rst_n || !en) stage[0] <= 1'b0;
                else               stage[0] <= ovr_in;
            end
        end else begin : g_body
            // Later stages pass the indication one step along.
            always_ff @(posedge clk) begin
                if (!rst_n || !en) stage[gi] <= 1'b0;
                else               stage[gi] <= stage[gi-1];
            end
        end
    end

    assign flag = stage[LAT-1];

    assert_ovr_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !flag);
    assert_ovr_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (stage == '0));
endmodule

// File: rtl/level_flag_det.sv
// Top of the level threshold detector: magnitude, upper flag, dwell-qualified
// lower flag and delayed overrange flag.
// Assumes: one two's complement sample per clock; levels are magnitudes.
module level_flag_det
    import level_flag_pkg::*;
#(
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned DWELL_W = DEF_DWELL_W,
    parameter int unsigned OVR_LAT = DEF_OVR_LAT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               det_en,
    input  logic [DATA_W-1:0]  smp,
    input  logic               smp_ovr,
    input  logic [DATA_W-2:0]  upper_lvl,
    input  logic [DATA_W-2:0]  lower_lvl,
    input  logic [DWELL_W-1:0] dwell_len,
    output logic               hi_flag,
    output logic               lo_flag,
    output logic               ovr_flag
);
    localparam int unsigned MAG_W = DATA_W - 1;

    logic [DATA_W-1:0] neg_smp;
    logic [MAG_W-1:0]  smp_mag;

    // Absolute value with the most negative code saturated.
    always_comb begin
        neg_smp = ~smp + 1'b1;
        if (!smp[DATA_W-1])          smp_mag = smp[MAG_W-1:0];
        else if (neg_smp[DATA_W-1])  smp_mag = '1;
        else                         smp_mag = neg_smp[MAG_W-1:0];
    end

    level_flag_upper #(.MAG_W(MAG_W)) i_upper (
        .clk(clk), .rst_n(rst_n), .en(det_en), .mag(smp_mag),
        .upper_lvl(upper_lvl), .flag(hi_flag)
    );

    level_flag_dwell #(.MAG_W(MAG_W), .DWELL_W(DWELL_W)) i_dwell (
        .clk(clk), .rst_n(rst_n), .en(det_en), .mag(smp_mag),
        .lower_lvl(lower_lvl), .dwell_len(dwell_len), .flag(lo_flag)
    );

    level_flag_ovr_pipe #(.LAT(OVR_LAT)) i_ovr (
        .clk(clk), .rst_n(rst_n), .en(det_en), .ovr_in(smp_ovr), .flag(ovr_flag)
    );

    assert_mag_sat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && smp == {1'b1, {(DATA_W-1){1'b0}}} && upper_lvl != '1) |=> hi_flag);
    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (!hi_flag && !lo_flag && !ovr_flag));
endmodule

// File: tb/test_level_flag_det.sv
module test_level_flag_det;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LAT = 12;

    logic        clk = 1'b0;
    logic        rst_n, det_en, smp_ovr;
    logic [13:0] smp;
    logic [12:0] upper_lvl, lower_lvl;
    logic [15:0] dwell_len;
    logic        hi_flag, lo_flag, ovr_flag;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    int  run = 0;
    bit  q [LAT];
    bit  e_hi = 1'b0, e_lo = 1'b0, e_ovr = 1'b0;

    always #2 clk = ~clk;

    level_flag_det i_level_flag_det (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .smp(smp), .smp_ovr(smp_ovr),
        .upper_lvl(upper_lvl), .lower_lvl(lower_lvl), .dwell_len(dwell_len),
        .hi_flag(hi_flag), .lo_flag(lo_flag), .ovr_flag(ovr_flag)
    );

    function automatic int mag_of(logic [13:0] s);
        int v = int'($signed(s));
        if (v < 0) v = -v;
        if (v > 8191) v = 8191;
        return v;
    endfunction

    task automatic chk(string tag, string what, logic got, logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, got, exp);
        end
    endtask

    // Drive one sample at a falling edge, model the rising edge, compare after.
    task automatic step(logic [13:0] s, logic o);
        int m;
        smp = s;
        smp_ovr = o;
        @(posedge clk);
        m = mag_of(s);
        if (!rst_n || !det_en) begin
            run = 0; e_hi = 0; e_lo = 0;
            for (int i = 0; i < LAT; i++) q[i] = 0;
        end else begin
            e_hi = (m > int'(upper_lvl));
            if (m >= int'(lower_lvl)) run = 0; else run++;
            e_lo = (run >= ((dwell_len == 0) ? 1 : int'(dwell_len)));
            for (int i = LAT - 1; i > 0; i--) q[i] = q[i-1];
            q[0] = o;
        end
        e_ovr = q[LAT-1];
        @(negedge clk);
        chk("R2", "hi_flag", hi_flag, e_hi);
        chk("R3", "lo_flag", lo_flag, e_lo);
        chk("R7", "ovr_flag", ovr_flag, e_ovr);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; det_en = 1; smp = 0; smp_ovr = 0;
        upper_lvl = 13'd4000; lower_lvl = 13'd200; dwell_len = 16'd1;
        for (int i = 0; i < LAT; i++) q[i] = 0;
        @(negedge clk);
        // R9: reset holds everything low despite loud, quiet and overrange input
        repeat (3) step(14'd8000, 1'b1);
        step(14'd0, 1'b1);
        chk("R9", "hi_flag reset", hi_flag, 1'b0);
        chk("R9", "lo_flag reset", lo_flag, 1'b0);
        chk("R9", "ovr_flag reset", ovr_flag, 1'b0);
        rst_n = 1;

        // R2: equality does not trip; one above does, either sign
        dwell_len = 16'd3;
        step(14'd4000, 0); chk("R2", "equal level", hi_flag, 1'b0);
        step(14'd4001, 0); chk("R2", "above level", hi_flag, 1'b1);
        step(14'(-4001), 0); chk("R2", "negative above", hi_flag, 1'b1);
        step(14'd300, 0);  chk("R2", "below level", hi_flag, 1'b0);

        // R1: most negative code saturates to 8191
        upper_lvl = 13'd8190;
        step(14'h2000, 0); chk("R1", "most negative vs 8190", hi_flag, 1'b1);
        upper_lvl = 13'd8191;
        step(14'h2000, 0); chk("R1", "most negative vs 8191", hi_flag, 1'b0);
        step(14'h1FFF, 0); chk("R1", "max positive vs 8191", hi_flag, 1'b0);

        // R3: three quiet samples needed
        step(14'd10, 0);  chk("R3", "dwell 1 of 3", lo_flag, 1'b0);
        step(14'(-10), 0); chk("R3", "dwell 2 of 3", lo_flag, 1'b0);
        step(14'd199, 0); chk("R3", "dwell 3 of 3", lo_flag, 1'b1);
        step(14'd5, 0);   chk("R3", "dwell held", lo_flag, 1'b1);

        // R4: sample on the level breaks the run and restarts the count
        step(14'd200, 0); chk("R4", "equal breaks", lo_flag, 1'b0);
        step(14'd1, 0);   chk("R4", "restart 1", lo_flag, 1'b0);
        step(14'd1, 0);   chk("R4", "restart 2", lo_flag, 1'b0);
        step(14'd1, 0);   chk("R4", "restart 3", lo_flag, 1'b1);
        step(14'(-200), 0); chk("R4", "negative equal breaks", lo_flag, 1'b0);

        // R5: dwell zero acts as one
        dwell_len = 16'd0;
        step(14'd300, 0); step(14'd3, 0);
        chk("R5", "dwell zero", lo_flag, 1'b1);

        // R7: single overrange pulse emerges exactly 12 cycles later
        step(14'd0, 1'b1);
        repeat (10) step(14'd0, 1'b0);
        chk("R7", "pulse not yet", ovr_flag, 1'b0);
        step(14'd0, 1'b0); chk("R7", "pulse at 12", ovr_flag, 1'b1);
        step(14'd0, 1'b0); chk("R7", "pulse gone", ovr_flag, 1'b0);

        // R8: disabled cycles hold flags low and flush state
        dwell_len = 16'd1;
        step(14'd0, 1'b1); step(14'd0, 1'b1);
        det_en = 0;
        step(14'd5, 1'b1);
        chk("R8", "lo off", lo_flag, 1'b0);
        chk("R8", "ovr off", ovr_flag, 1'b0);
        step(14'd8100, 1'b1);
        chk("R8", "hi off", hi_flag, 1'b0);
        det_en = 1; dwell_len = 16'd2;
        step(14'd5, 0); chk("R8", "count restarted", lo_flag, 1'b0);
        step(14'd5, 0); chk("R8", "count resumes", lo_flag, 1'b1);
        repeat (LAT) begin
            step(14'd5, 0); chk("R8", "flushed overrange", ovr_flag, 1'b0);
        end

        // Random blocks
        for (int blk = 0; blk < 15; blk++) begin
            int lo_v = 50 + $urandom_range(0, 1500);
            int hi_v = lo_v + $urandom_range(0, 6000);
            if (hi_v > 8191) hi_v = 8191;
            lower_lvl = 13'(lo_v);
            upper_lvl = 13'(hi_v);
            dwell_len = 16'($urandom_range(1, 24));
            for (int k = 0; k < 200; k++) begin
                logic [13:0] s;
                int v;
                det_en = ($urandom_range(0, 49) != 0);
                case ($urandom_range(0, 5))
                    0, 1, 2: v = $urandom_range(0, lo_v - 1);
                    3: v = $urandom_range(0, 8191);
                    4: v = hi_v + $urandom_range(0, 2) - 1;
                    default: v = lo_v + $urandom_range(0, 2) - 1;
                endcase
                if (v > 8191) v = 8191;
                s = $urandom_range(0, 1) ? 14'(-v) : 14'(v);
                if ($urandom_range(0, 63) == 0) s = 14'h2000;
                step(s, $urandom_range(0, 9) == 0);
            end
        end
        det_en = 1;

        // R6: full 16-bit dwell
        lower_lvl = 13'd200; upper_lvl = 13'd8191; dwell_len = 16'hFFFF;
        step(14'd300, 0);
        repeat (65534) step(14'd7, 0);
        chk("R6", "65534 quiet", lo_flag, 1'b0);
        step(14'd7, 0); chk("R6", "65535 quiet", lo_flag, 1'b1);
        repeat (3) step(14'd7, 0);
        chk("R6", "held past max", lo_flag, 1'b1);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule